// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This block owns the 32-bit instruction address of a simple in-order core and decides, every time the core advances, where the next instruction lives. It looks at the instruction word currently being executed together with the two source operand values. From these it resolves conditional branches, the PC-relative jump, the register-indirect jump and the add-upper-immediate-to-PC operation. It rebuilds each operation's immediate from its scattered fields and produces the next address.

The unit also produces the value the register file should write back for the linking jumps and for the PC-relative upper-immediate operation, along with the destination index and a write strobe. A redirect to an address that is not on a 4-byte boundary is refused: the unit raises a flag, keeps the address where it is and drops the write-back. Instruction fetch, the register file and the arithmetic unit live elsewhere. The core drives `step_en` high for each instruction it retires.

Top module: `pcu_top`

## Requirements
- R1: While `rst` is high at a rising edge, the PC loads `rst_vec`. When `step_en` is low, the PC keeps its value.
- R2: A step on any instruction whose opcode (bits 6:0) is none of 1100011, 1101111, 1100111 advances the PC by 4.
- R3: For opcode 1100011, bits 14:12 choose the condition: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. The comparison is operand A against operand B. Codes 010 and 011 are never taken. A branch that is not taken advances the PC by 4.
- R4: A taken branch moves the PC to PC + offset. The offset is sign-extended from bit 12 and is built with bit 12 from instr[31], bit 11 from instr[7], bits 10:5 from instr[30:25], bits 4:1 from instr[11:8], and bit 0 set to zero.
- R5: Opcode 1101111 moves the PC to PC + offset. The offset is sign-extended from bit 20 and is built with bit 20 from instr[31], bits 19:12 from instr[19:12], bit 11 from instr[20], bits 10:1 from instr[30:21], and bit 0 set to zero.
- R6: Opcode 1100111 moves the PC to operand A + sign-extended instr[31:20], with no scaling and with bit 0 of the sum cleared.
- R7: Opcodes 1101111 and 1100111 present PC + 4 on `link_val_o`. They present instr[11:7] on `link_rd_o` and raise `link_we_o`.
- R8: Opcode 0010111 presents PC + (instr[31:12] << 12) on `link_val_o` with `link_we_o` high, and the PC advances by 4.
- R9: `link_we_o` stays low whenever the destination index instr[11:7] is 0.
- R10: If a redirect target (taken branch, jump, or register jump after clearing bit 0) has bits 1:0 not equal to 00, then `misalign_o` is high, `link_we_o` is low and the PC does not change.
- R11: While `step_en` is low, `link_we_o` and `misalign_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rst_vec | input | 32 | Address loaded into the PC during reset |
| step_en | input | 1 | Retire the current instruction this cycle |
| instr | input | 32 | Instruction word being executed |
| opa | input | 32 | First source operand value |
| opb | input | 32 | Second source operand value |
| pc_o | output | 32 | Current program counter |
| link_val_o | output | 32 | Write-back value for the destination register |
| link_we_o | output | 1 | Write-back strobe |
| link_rd_o | output | 5 | Destination register index |
| misalign_o | output | 1 | Redirect target not 4-byte aligned; step refused |

## Verification
The bench aims at operand pairs where signed and unsigned ordering disagree, such as all-ones against one, and at equal operands. A design that mixed up the two comparison kinds, or that got the greater-or-equal boundary wrong, would take the wrong path at these points. Negative offsets with every scattered immediate bit set show up any field taken from the wrong instruction bit, because the PC lands at a different address. Odd register bases check that bit 0 is cleared on register jumps and that bit 1 still trips the alignment flag. A design that updated the PC on a refused step, or wrote back to register 0, would show the wrong PC or a stray write strobe.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int XLEN       = 32;
    localparam int INSN_BYTES = 4;
    localparam int RIDX_W     = 5;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;

    localparam logic [2:0] CND_EQ  = 3'b000;
    localparam logic [2:0] CND_NE  = 3'b001;
    localparam logic [2:0] CND_LT  = 3'b100;
    localparam logic [2:0] CND_GE  = 3'b101;
    localparam logic [2:0] CND_LTU = 3'b110;
    localparam logic [2:0] CND_GEU = 3'b111;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BRANCH,
        FLOW_JAL,
        FLOW_JALR,
        FLOW_AUIPC
    } flow_e;

    typedef struct packed {
        flow_e      kind;
        logic [2:0] cond;
        ridx_t      rd;
        word_t      imm;
    } dec_t;

    typedef struct packed {
        logic  redirect;
        word_t target;
        logic  link_req;
        word_t link_val;
        word_t seq_pc;
    } nxt_t;

    function automatic word_t imm_branch(input logic [31:0] w);
        return {{(XLEN-12){w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic word_t imm_jump(input logic [31:0] w);
        return {{(XLEN-20){w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
    endfunction

    function automatic word_t imm_itype(input logic [31:0] w);
        return {{(XLEN-12){w[31]}}, w[31:20]};
    endfunction

    function automatic word_t imm_upper(input logic [31:0] w);
        return {w[31:12], 12'b0};
    endfunction

    function automatic flow_e classify(input logic [6:0] opc);
        case (opc)
            OPC_BRANCH: return FLOW_BRANCH;
            OPC_JAL:    return FLOW_JAL;
            OPC_JALR:   return FLOW_JALR;
            OPC_AUIPC:  return FLOW_AUIPC;
            default:    return FLOW_SEQ;
        endcase
    endfunction

endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    flow_e kind;

    always_comb begin
        kind     = classify(instr[6:0]);
        dec.kind = kind;
        dec.cond = instr[14:12];
        dec.rd   = instr[11:7];
        case (kind)
            FLOW_BRANCH: dec.imm = imm_branch(instr);
            FLOW_JAL:    dec.imm = imm_jump(instr);
            FLOW_JALR:   dec.imm = imm_itype(instr);
            FLOW_AUIPC:  dec.imm = imm_upper(instr);
            default:     dec.imm = '0;
        endcase
    end
endmodule

// File: rtl/pcu_branch_cmp.sv
module pcu_branch_cmp
    import pcu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   cond,
    output logic         take
);
    logic eq, lt_s, lt_u;

    always_comb begin
        eq   = (a == b);
        lt_u = (a < b);
        lt_s = ($signed(a) < $signed(b));
        case (cond)
            CND_EQ:  take = eq;
            CND_NE:  take = !eq;
            CND_LT:  take = lt_s;
            CND_GE:  take = !lt_s;
            CND_LTU: take = lt_u;
            CND_GEU: take = !lt_u;
            default: take = 1'b0;
        endcase
    end

    always_comb begin
        AST_EQ_EXCLUDES_LT: assert (!(eq && (lt_s || lt_u))); // R3
    end
endmodule

// File: rtl/pcu_next.sv
module pcu_next
    import pcu_pkg::*;
(
    input  dec_t  dec,
    input  word_t pc,
    input  word_t opa,
    input  logic  take,
    output nxt_t  nxt
);
    word_t base, sum;

    always_comb begin
        base = (dec.kind == FLOW_JALR) ? opa : pc;
        sum  = base + dec.imm;

        nxt.seq_pc   = pc + word_t'(INSN_BYTES);
        nxt.redirect = 1'b0;
        nxt.target   = sum;
        nxt.link_req = 1'b0;
        nxt.link_val = nxt.seq_pc;

        case (dec.kind)
            FLOW_BRANCH: nxt.redirect = take;
            FLOW_JAL: begin
                nxt.redirect = 1'b1;
                nxt.link_req = 1'b1;
            end
            FLOW_JALR: begin
                nxt.redirect = 1'b1;
                nxt.link_req = 1'b1;
                nxt.target   = {sum[XLEN-1:1], 1'b0};
            end
            FLOW_AUIPC: begin
                nxt.link_req = 1'b1;
                nxt.link_val = sum;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int ALIGN_BITS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] rst_vec,
    input  logic        step_en,
    input  logic [31:0] instr,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    output logic [31:0] pc_o,
    output logic [31:0] link_val_o,
    output logic        link_we_o,
    output logic [4:0]  link_rd_o,
    output logic        misalign_o
);
    localparam logic [ALIGN_BITS-1:0] ALIGN_ZERO = '0;

    word_t pc_q, pc_d;
    dec_t  dec;
    nxt_t  nxt;
    logic  take;

    pcu_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    pcu_branch_cmp #(.W(XLEN)) u_cmp (
        .a    (opa),
        .b    (opb),
        .cond (dec.cond),
        .take (take)
    );

    pcu_next u_next (
        .dec  (dec),
        .pc   (pc_q),
        .opa  (opa),
        .take (take),
        .nxt  (nxt)
    );

    always_comb begin
        misalign_o = step_en && nxt.redirect &&
                     (nxt.target[ALIGN_BITS-1:0] != ALIGN_ZERO);
        link_we_o  = step_en && nxt.link_req && !misalign_o && (dec.rd != '0);
        link_val_o = nxt.link_val;
        link_rd_o  = dec.rd;
        pc_d       = nxt.redirect ? nxt.target : nxt.seq_pc;
        pc_o       = pc_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= rst_vec;
        else if (step_en && !misalign_o)
            pc_q <= pc_d;
    end

    AST_RESET_LOADS_VEC: assert property (@(posedge clk)
        rst |=> pc_q == $past(rst_vec)); // R1
    AST_IDLE_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pc_q)); // R1
    AST_MISALIGN_FREEZES: assert property (@(posedge clk) disable iff (rst)
        misalign_o |=> $stable(pc_q)); // R10
    AST_NO_WB_ON_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> !link_we_o); // R10
    AST_ALIGNED_STAYS: assert property (@(posedge clk) disable iff (rst)
        (step_en && pc_q[ALIGN_BITS-1:0] == ALIGN_ZERO)
        |=> pc_q[ALIGN_BITS-1:0] == ALIGN_ZERO); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !step_en |-> (!link_we_o && !misalign_o)); // R11
    AST_NO_WB_X0: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> link_rd_o != 5'd0); // R9
endmodule

// File: tb/pcu_top_tb.sv
module pcu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] rst_vec, instr, opa, opb;
    logic        step_en;
    logic [31:0] pc_o, link_val_o;
    logic        link_we_o, misalign_o;
    logic [4:0]  link_rd_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mpc;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    pcu_top dut_i (
        .clk(clk), .rst(rst), .rst_vec(rst_vec), .step_en(step_en),
        .instr(instr), .opa(opa), .opb(opb), .pc_o(pc_o),
        .link_val_o(link_val_o), .link_we_o(link_we_o),
        .link_rd_o(link_rd_o), .misalign_o(misalign_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model built from the requirement text.
    task automatic model(input logic [31:0] w, input logic [31:0] pc,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic redir, output logic [31:0] tgt,
                         output logic lreq, output logic [31:0] lval);
        logic [31:0] ob, oj, oi;
        logic        t;
        ob = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        oj = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        oi = {{20{w[31]}}, w[31:20]};
        redir = 1'b0; tgt = pc + 4; lreq = 1'b0; lval = pc + 4;
        case (w[6:0])
            7'b1100011: begin
                case (w[14:12])
                    3'd0: t = (a == b);
                    3'd1: t = (a != b);
                    3'd4: t = ($signed(a) <  $signed(b));
                    3'd5: t = ($signed(a) >= $signed(b));
                    3'd6: t = (a <  b);
                    3'd7: t = (a >= b);
                    default: t = 1'b0;
                endcase
                if (t) begin redir = 1'b1; tgt = pc + ob; end
            end
            7'b1101111: begin redir = 1'b1; tgt = pc + oj; lreq = 1'b1; end
            7'b1100111: begin redir = 1'b1; tgt = (a + oi) & ~32'd1; lreq = 1'b1; end
            7'b0010111: begin lreq = 1'b1; lval = pc + {w[31:12], 12'd0}; end
            default: ;
        endcase
    endtask

    task automatic step(input logic [31:0] w, input logic [31:0] a,
                        input logic [31:0] b, input logic en, input string req);
        logic redir, lreq, mis, we;
        logic [31:0] tgt, lval, npc;
        @(negedge clk);
        instr = w; opa = a; opb = b; step_en = en;
        #1;
        model(w, mpc, a, b, redir, tgt, lreq, lval);
        mis = en && redir && (tgt[1:0] != 2'b00);
        we  = en && lreq && !mis && (w[11:7] != 5'd0);
        chk({req, " misalign"}, {31'd0, misalign_o}, {31'd0, mis});
        chk({req, " link_we"},  {31'd0, link_we_o},  {31'd0, we});
        if (we) begin
            chk({req, " link_val"}, link_val_o, lval);
            chk({req, " link_rd"},  {27'd0, link_rd_o}, {27'd0, w[11:7]});
        end
        npc = (!en || mis) ? mpc : tgt;
        @(posedge clk);
        #1;
        mpc = npc;
        chk({req, " pc"}, pc_o, mpc);
    endtask

    function automatic logic [31:0] mk_b(input logic [12:0] off, input logic [2:0] f3);
        return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] mk_j(input logic [20:0] off, input logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] mk_i(input logic [11:0] imm, input logic [4:0] rd);
        return {imm, 5'd1, 3'b000, rd, 7'b1100111};
    endfunction

    initial begin
        #1500000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5A17C0DE);
        rst = 1'b1; rst_vec = 32'h0000_1000; step_en = 1'b0;
        instr = 32'h0000_0013; opa = '0; opb = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset vector", pc_o, 32'h0000_1000);
        @(negedge clk); rst = 1'b0;
        mpc = 32'h0000_1000;

        // R1 / R11: idle step holds and stays quiet, even on a jump
        step(mk_j(21'd64, 5'd1), 0, 0, 1'b0, "R1 R11 idle");
        // R2: plain op
        step(32'h0050_0093, 0, 0, 1'b1, "R2 seq");
        // R3/R4: beq taken, forward offset with imm[11] set
        step(mk_b(13'h0804, 3'd0), 32'd7, 32'd7, 1'b1, "R3 R4 beq taken");
        step(mk_b(13'h0010, 3'd1), 32'd7, 32'd7, 1'b1, "R3 bne not taken");
        // signed vs unsigned disagreement
        step(mk_b(13'h1FF0, 3'd4), 32'hFFFF_FFFF, 32'd1, 1'b1, "R3 R4 blt signed taken");
        step(mk_b(13'h0020, 3'd6), 32'hFFFF_FFFF, 32'd1, 1'b1, "R3 bltu not taken");
        step(mk_b(13'h0020, 3'd5), 32'd5, 32'd5, 1'b1, "R3 bge equal taken");
        step(mk_b(13'h0040, 3'd7), 32'd1, 32'hFFFF_FFFF, 1'b1, "R3 bgeu not taken");
        step(mk_b(13'h0040, 3'd2), 32'd1, 32'd1, 1'b1, "R3 code 010 never taken");
        // R5/R7: jal backward, rd=5
        step(mk_j(21'h1F_F800, 5'd5), 0, 0, 1'b1, "R5 R7 jal back");
        step(mk_j(21'h00_1000, 5'd0), 0, 0, 1'b1, "R9 jal rd0");
        // R6: jalr odd base, bit0 cleared -> aligned
        step(mk_i(12'd3, 5'd1), 32'h0000_2001, 0, 1'b1, "R6 R7 jalr odd base");
        step(mk_i(12'hFFC, 5'd3), 32'h0000_3008, 0, 1'b1, "R6 jalr neg imm");
        // R10: misaligned jalr and branch
        step(mk_i(12'd0, 5'd4), 32'h0000_4002, 0, 1'b1, "R10 jalr misaligned");
        step(mk_b(13'h0006, 3'd0), 32'd0, 32'd0, 1'b1, "R10 branch misaligned");
        step(mk_j(21'd2, 5'd6), 0, 0, 1'b1, "R10 jal misaligned");
        // R8: auipc
        step({20'h87654, 5'd10, 7'b0010111}, 0, 0, 1'b1, "R8 auipc");
        step({20'hFFFFF, 5'd0, 7'b0010111}, 0, 0, 1'b1, "R8 R9 auipc rd0");

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w, a, b;
            int sel;
            w = $urandom; a = $urandom; b = $urandom;
            sel = $urandom_range(0, 5);
            if ($urandom_range(0, 3) == 0) b = a;
            case (sel)
                0: begin w[6:0] = 7'b1100011; if ($urandom_range(0, 7) != 0) w[8] = 1'b0; end
                1: begin w[6:0] = 7'b1101111; if ($urandom_range(0, 7) != 0) w[21] = 1'b0; end
                2: begin w[6:0] = 7'b1100111; if ($urandom_range(0, 7) != 0) begin w[21] = 1'b0; a[1] = 1'b0; end end
                3: w[6:0] = 7'b0010111;
                default: w[6:0] = 7'b0110011;
            endcase
            step(w, a, b, ($urandom_range(0, 9) != 0), "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1; rst_vec = 32'h8000_0000;
        @(posedge clk); #1;
        chk("R1 reset mid-run", pc_o, 32'h8000_0000);
        @(negedge clk); rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule